// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home agent for one slice of distributed physical memory. Each memory line has a fixed home, chosen by its physical address, and the home keeps a directory entry for it. The entry holds a state (Uncached, Shared or Modified), a sharer bit-vector with one bit per node, and an owner index that is meaningful only while the line is Modified. Nodes send read and write requests as point-to-point messages. The home answers with data, grants, retries, targeted invalidations or fetches to the current owner.

Invalidations go only to the nodes recorded in the sharer vector; nothing is broadcast. A write that needs invalidations is granted only after every invalidated node has acknowledged. A request that meets a Modified line held by another node makes the home fetch the line from its owner first. Each line allows one pending transaction. Its busy flag turns every other request to that line into a retry. A small behavioural store holds one data word per line.

Each request is answered on the request-reply channel one cycle after it arrives. Transactions that wait for acknowledgements or a write-back finish on a separate completion channel, one cycle after the response that closes them. Destinations are bit-masks in which bit i selects node i.

Top module: `hcDirHome`

## Requirements
- R1: After reset every line is Uncached with no sharers and not busy, and the store holds the line index as its data word; no output message is valid.
- R2: Every valid request produces exactly one request-channel message one cycle later, carrying the request's line. DATA (type 0), GRANT (type 1) and NACK (type 2) are addressed only to the requester. The data field is zero for NACK, INV and FETCH messages.
- R3: A read to an Uncached or Shared line replies DATA with the stored word. It adds the requester to the sharers and leaves the line Shared.
- R4: A write to an Uncached or Shared line with no sharer other than the requester replies GRANT with the stored word at once. The line becomes Modified, with the requester as owner and sole sharer.
- R5: A write to a Shared line with other sharers sends one INV message (type 3). Its destination mask is exactly the sharers minus the requester. The line becomes busy, with an acknowledgement count equal to the number of invalidated nodes.
- R6: On such a busy line each ACK response (response kind 0) lowers the count. The last ACK produces a GRANT to the writer on the completion channel one cycle later, carrying the stored word, and makes the writer the sole owner. No completion appears before the last ACK.
- R7: A request to a busy line is answered with NACK and leaves the directory unchanged.
- R8: A request from another node to a Modified line sends FETCH (type 4) for a read or FETCHINV (type 5) for a write. The message goes only to the owner and makes the line busy.
- R9: The owner's write-back (response kind 1) to a pending fetch stores its data. For a read it sends DATA with that data to the requester on the completion channel and leaves the line Shared with owner and requester as sharers. For a write it sends GRANT with that data and makes the requester the sole owner.
- R10: A request from the current owner of a Modified line is answered with GRANT and the stored word, with no directory change.
- R11: An unsolicited write-back from the owner of a non-busy Modified line stores its data and makes the line Uncached. A request to the same line in the same cycle is answered with NACK.
- R12: An ACK to a non-busy line, or a write-back from a node that is not the owner, is ignored: no completion and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write (exclusive) request, 0 = read |
| reqSrc | input | NODE_W | Requesting node index |
| reqLine | input | LINE_W | Line addressed by the request |
| rspValid | input | 1 | Response present |
| rspWb | input | 1 | Response kind: 0 = invalidate ACK, 1 = write-back with data |
| rspSrc | input | NODE_W | Responding node index |
| rspLine | input | LINE_W | Line the response refers to |
| rspData | input | DATA_W | Write-back data |
| outValid | output | 1 | Request-channel message valid |
| outType | output | 3 | Message type (0 DATA, 1 GRANT, 2 NACK, 3 INV, 4 FETCH, 5 FETCHINV) |
| outDst | output | NODES | Destination node mask |
| outLine | output | LINE_W | Line of the message |
| outData | output | DATA_W | Message data |
| cplValid | output | 1 | Completion-channel message valid |
| cplType | output | 3 | Completion type (0 DATA, 1 GRANT) |
| cplDst | output | NODES | Completion destination mask |
| cplLine | output | LINE_W | Completion line |
| cplData | output | DATA_W | Completion data |

## Verification
The bench sweeps all eight lines with one to four readers. Writers are chosen so that both the direct-grant and the invalidation paths occur, and the acknowledgement count has lengths one to three. A counter that granted one acknowledgement early, or that invalidated the requester itself, would show an early completion or a wrong INV mask. Owner transfers are exercised through read fetches and write fetches. A design that dropped the write-back data, or recorded the wrong sharers after a read fetch, would return stale data or send invalidations to the wrong nodes. Stray acknowledgements, write-backs from non-owners and a request that collides with an eviction are also driven. A design that acted on any of them would emit a spurious completion or lose the evicted data.

// File: rtl/hcDirPkg.sv
package hcDirPkg;
  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_MOD = 2'd2
  } dirState_e;

  typedef enum logic [2:0] {
    MSG_DATA     = 3'd0,
    MSG_GRANT    = 3'd1,
    MSG_NACK     = 3'd2,
    MSG_INV      = 3'd3,
    MSG_FETCH    = 3'd4,
    MSG_FETCHINV = 3'd5
  } msgType_e;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic nack;
    logic readDirect;
    logic writeDirect;
    logic ownerHit;
    logic invStart;
    logic fetchStart;
    logic ackDec;
    logic ackDone;
    logic wbDone;
    logic evict;
  } dirStrobe_t;
endpackage

// File: rtl/hcDirDp.sv
module hcDirDp
  import hcDirPkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 8,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [NODE_W-1:0] rspSrc,
  input  logic [LINE_W-1:0] rspLine,
  input  logic [DATA_W-1:0] rspData,
  output dirState_e         rqState,
  output logic [NODES-1:0]  rqShr,
  output logic [NODE_W-1:0] rqOwn,
  output logic              rqBusy,
  output dirState_e         rsState,
  output logic [NODE_W-1:0] rsOwn,
  output logic              rsBusy,
  output logic [CNT_W-1:0]  rsCnt,
  output logic              rsWaitWb,
  output logic              outValid,
  output msgType_e          outType,
  output logic [NODES-1:0]  outDst,
  output logic [LINE_W-1:0] outLine,
  output logic [DATA_W-1:0] outData,
  output logic              cplValid,
  output msgType_e          cplType,
  output logic [NODES-1:0]  cplDst,
  output logic [LINE_W-1:0] cplLine,
  output logic [DATA_W-1:0] cplData
);
  localparam logic [NODES-1:0] ONE_HOT0 = NODES'(1);

  dirState_e         stateQ   [LINES];
  logic [NODES-1:0]  shrQ     [LINES];
  logic [NODE_W-1:0] ownQ     [LINES];
  logic              busyQ    [LINES];
  logic [CNT_W-1:0]  cntQ     [LINES];
  logic              waitWbQ  [LINES];
  logic [NODE_W-1:0] pendSrcQ [LINES];
  logic              pendWrQ  [LINES];
  logic [DATA_W-1:0] memQ     [LINES];

  function automatic logic [CNT_W-1:0] popCnt(input logic [NODES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int k = 0; k < NODES; k++) c = c + CNT_W'(v[k]);
    return c;
  endfunction

  logic [NODES-1:0] srcBit, others, pendBit, ownBit;
  logic [NODE_W-1:0] rsPend;

  assign rqState  = stateQ[reqLine];
  assign rqShr    = shrQ[reqLine];
  assign rqOwn    = ownQ[reqLine];
  assign rqBusy   = busyQ[reqLine];
  assign rsState  = stateQ[rspLine];
  assign rsOwn    = ownQ[rspLine];
  assign rsBusy   = busyQ[rspLine];
  assign rsCnt    = cntQ[rspLine];
  assign rsWaitWb = waitWbQ[rspLine];
  assign rsPend   = pendSrcQ[rspLine];
  assign srcBit   = ONE_HOT0 << reqSrc;
  assign others   = rqShr & ~srcBit;
  assign pendBit  = ONE_HOT0 << rsPend;
  assign ownBit   = ONE_HOT0 << rsOwn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i]   <= DIR_UNC;
        shrQ[i]     <= '0;
        ownQ[i]     <= '0;
        busyQ[i]    <= 1'b0;
        cntQ[i]     <= '0;
        waitWbQ[i]  <= 1'b0;
        pendSrcQ[i] <= '0;
        pendWrQ[i]  <= 1'b0;
        memQ[i]     <= DATA_W'(i);
      end
      outValid <= 1'b0;
      outType  <= MSG_DATA;
      outDst   <= '0;
      outLine  <= '0;
      outData  <= '0;
      cplValid <= 1'b0;
      cplType  <= MSG_DATA;
      cplDst   <= '0;
      cplLine  <= '0;
      cplData  <= '0;
    end else begin
      // request-reply channel
      outValid <= stb.nack | stb.readDirect | stb.writeDirect | stb.ownerHit |
                  stb.invStart | stb.fetchStart;
      outLine  <= reqLine;
      outDst   <= srcBit;
      outData  <= '0;
      outType  <= MSG_NACK;
      if (stb.readDirect) begin
        stateQ[reqLine] <= DIR_SHR;
        shrQ[reqLine]   <= rqShr | srcBit;
        outType         <= MSG_DATA;
        outData         <= memQ[reqLine];
      end
      if (stb.writeDirect) begin
        stateQ[reqLine] <= DIR_MOD;
        shrQ[reqLine]   <= srcBit;
        ownQ[reqLine]   <= reqSrc;
        outType         <= MSG_GRANT;
        outData         <= memQ[reqLine];
      end
      if (stb.ownerHit) begin
        outType <= MSG_GRANT;
        outData <= memQ[reqLine];
      end
      if (stb.invStart || stb.fetchStart) begin
        busyQ[reqLine]    <= 1'b1;
        pendSrcQ[reqLine] <= reqSrc;
        pendWrQ[reqLine]  <= reqWrite | stb.invStart;
        waitWbQ[reqLine]  <= stb.fetchStart;
        cntQ[reqLine]     <= stb.invStart ? popCnt(others) : '0;
      end
      if (stb.invStart) begin
        outType <= MSG_INV;
        outDst  <= others;
      end
      if (stb.fetchStart) begin
        outType <= reqWrite ? MSG_FETCHINV : MSG_FETCH;
        outDst  <= ONE_HOT0 << rqOwn;
      end

      // completion channel
      cplValid <= stb.ackDone | stb.wbDone;
      cplLine  <= rspLine;
      cplDst   <= pendBit;
      cplType  <= MSG_GRANT;
      cplData  <= memQ[rspLine];
      if (stb.ackDec) cntQ[rspLine] <= rsCnt - CNT_W'(1);
      if (stb.ackDone || stb.wbDone) begin
        busyQ[rspLine]   <= 1'b0;
        waitWbQ[rspLine] <= 1'b0;
        cntQ[rspLine]    <= '0;
      end
      if (stb.ackDone || (stb.wbDone && pendWrQ[rspLine])) begin
        stateQ[rspLine] <= DIR_MOD;
        shrQ[rspLine]   <= pendBit;
        ownQ[rspLine]   <= rsPend;
      end
      if (stb.wbDone) begin
        memQ[rspLine] <= rspData;
        cplData       <= rspData;
        if (!pendWrQ[rspLine]) begin
          stateQ[rspLine] <= DIR_SHR;
          shrQ[rspLine]   <= ownBit | pendBit;
          cplType         <= MSG_DATA;
        end
      end
      if (stb.evict) begin
        memQ[rspLine]   <= rspData;
        stateQ[rspLine] <= DIR_UNC;
        shrQ[rspLine]   <= '0;
      end
    end
  end
endmodule

// File: rtl/hcDirCtrl.sv
module hcDirCtrl
  import hcDirPkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 8,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              rspValid,
  input  logic              rspWb,
  input  logic [NODE_W-1:0] rspSrc,
  input  logic [LINE_W-1:0] rspLine,
  input  dirState_e         rqState,
  input  logic [NODES-1:0]  rqShr,
  input  logic [NODE_W-1:0] rqOwn,
  input  logic              rqBusy,
  input  dirState_e         rsState,
  input  logic [NODE_W-1:0] rsOwn,
  input  logic              rsBusy,
  input  logic [CNT_W-1:0]  rsCnt,
  input  logic              rsWaitWb,
  output dirStrobe_t        stb
);
  logic othersZero;
  assign othersZero = (rqShr & ~(NODES'(1) << reqSrc)) == '0;

  always_comb begin
    stb = '0;
    if (rspValid) begin
      if (rsBusy) begin
        if (!rspWb && !rsWaitWb) begin
          if (rsCnt == CNT_W'(1)) stb.ackDone = 1'b1;
          else stb.ackDec = 1'b1;
        end else if (rspWb && rsWaitWb && rspSrc == rsOwn) begin
          stb.wbDone = 1'b1;
        end
      end else if (rspWb && rsState == DIR_MOD && rspSrc == rsOwn) begin
        stb.evict = 1'b1;
      end
    end
    if (reqValid) begin
      if (rqBusy || (stb.evict && rspLine == reqLine)) stb.nack = 1'b1;
      else if (rqState == DIR_MOD) begin
        if (rqOwn == reqSrc) stb.ownerHit = 1'b1;
        else stb.fetchStart = 1'b1;
      end else if (!reqWrite) stb.readDirect = 1'b1;
      else if (othersZero) stb.writeDirect = 1'b1;
      else stb.invStart = 1'b1;
    end
  end
endmodule

// File: rtl/hcDirHome.sv
module hcDirHome
  import hcDirPkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 8,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              rspValid,
  input  logic              rspWb,
  input  logic [NODE_W-1:0] rspSrc,
  input  logic [LINE_W-1:0] rspLine,
  input  logic [DATA_W-1:0] rspData,
  output logic              outValid,
  output logic [2:0]        outType,
  output logic [NODES-1:0]  outDst,
  output logic [LINE_W-1:0] outLine,
  output logic [DATA_W-1:0] outData,
  output logic              cplValid,
  output logic [2:0]        cplType,
  output logic [NODES-1:0]  cplDst,
  output logic [LINE_W-1:0] cplLine,
  output logic [DATA_W-1:0] cplData
);
  dirStrobe_t        stb;
  dirState_e         rqState, rsState;
  logic [NODES-1:0]  rqShr;
  logic [NODE_W-1:0] rqOwn, rsOwn;
  logic              rqBusy, rsBusy, rsWaitWb;
  logic [CNT_W-1:0]  rsCnt;
  msgType_e          outTypeE, cplTypeE;

  assign outType = outTypeE;
  assign cplType = cplTypeE;

  hcDirCtrl #(.NODES(NODES), .LINES(LINES)) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSrc(reqSrc), .reqLine(reqLine),
    .rspValid(rspValid), .rspWb(rspWb), .rspSrc(rspSrc), .rspLine(rspLine),
    .rqState(rqState), .rqShr(rqShr), .rqOwn(rqOwn), .rqBusy(rqBusy),
    .rsState(rsState), .rsOwn(rsOwn), .rsBusy(rsBusy), .rsCnt(rsCnt),
    .rsWaitWb(rsWaitWb), .stb(stb)
  );

  hcDirDp #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqSrc(reqSrc),
    .reqLine(reqLine), .rspSrc(rspSrc), .rspLine(rspLine), .rspData(rspData),
    .rqState(rqState), .rqShr(rqShr), .rqOwn(rqOwn), .rqBusy(rqBusy),
    .rsState(rsState), .rsOwn(rsOwn), .rsBusy(rsBusy), .rsCnt(rsCnt),
    .rsWaitWb(rsWaitWb),
    .outValid(outValid), .outType(outTypeE), .outDst(outDst), .outLine(outLine),
    .outData(outData), .cplValid(cplValid), .cplType(cplTypeE), .cplDst(cplDst),
    .cplLine(cplLine), .cplData(cplData)
  );
endmodule

// File: rtl/hcDirChk.sv
module hcDirChk #(
  parameter int NODES = 4,
  parameter int LINES = 8,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [NODE_W-1:0] reqSrc,
  input logic [LINE_W-1:0] reqLine,
  input logic              rspValid,
  input logic              outValid,
  input logic [2:0]        outType,
  input logic [NODES-1:0]  outDst,
  input logic [LINE_W-1:0] outLine,
  input logic              cplValid,
  input logic [2:0]        cplType,
  input logic [NODES-1:0]  cplDst
);
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R2
  AST_NO_UNASKED_OUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(reqValid)); // R2
  AST_LINE_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outLine == $past(reqLine)); // R2
  AST_REPLY_TO_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType <= 3'd2) |-> outDst == (NODES'(1) << $past(reqSrc))); // R2
  AST_INV_NOT_SELF: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType == 3'd3) |->
      ((outDst & (NODES'(1) << $past(reqSrc))) == '0 && outDst != '0)); // R5
  AST_FETCH_ONE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outType == 3'd4 || outType == 3'd5)) |-> $countones(outDst) == 1); // R8
  AST_CPL_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> $past(rspValid)); // R6
  AST_CPL_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> ($countones(cplDst) == 1 && cplType <= 3'd1)); // R9
endmodule

bind hcDirHome hcDirChk #(.NODES(NODES), .LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSrc(reqSrc), .reqLine(reqLine),
  .rspValid(rspValid), .outValid(outValid), .outType(outType), .outDst(outDst),
  .outLine(outLine), .cplValid(cplValid), .cplType(cplType), .cplDst(cplDst)
);

// File: tb/hcDirHome_bench.sv
`timescale 1ns/1ps
module hcDirHome_bench;
  localparam int NODES = 4, LINES = 8, DW = 8, NW = 2, LW = 3;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, rspValid = 0, rspWb = 0;
  logic [NW-1:0] reqSrc = '0, rspSrc = '0;
  logic [LW-1:0] reqLine = '0, rspLine = '0;
  logic [DW-1:0] rspData = '0;
  logic outValid, cplValid;
  logic [2:0] outType, cplType;
  logic [NODES-1:0] outDst, cplDst;
  logic [LW-1:0] outLine, cplLine;
  logic [DW-1:0] outData, cplData;

  int checks = 0, errs = 0;
  bit done = 0;

  hcDirHome #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) u_hcDirHome (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqSrc(reqSrc),
    .reqLine(reqLine), .rspValid(rspValid), .rspWb(rspWb), .rspSrc(rspSrc),
    .rspLine(rspLine), .rspData(rspData), .outValid(outValid), .outType(outType),
    .outDst(outDst), .outLine(outLine), .outData(outData), .cplValid(cplValid),
    .cplType(cplType), .cplDst(cplDst), .cplLine(cplLine), .cplData(cplData)
  );

  always #2.5 clk = ~clk;

  task automatic drive(input logic rv, input logic wr, input int src, input int line,
                       input logic sv, input logic wb, input int ssrc, input int sline,
                       input int sdata);
    @(negedge clk);
    reqValid = rv; reqWrite = wr; reqSrc = NW'(src); reqLine = LW'(line);
    rspValid = sv; rspWb = wb; rspSrc = NW'(ssrc); rspLine = LW'(sline);
    rspData = DW'(sdata);
    @(negedge clk);
    reqValid = 0; rspValid = 0;
  endtask

  task automatic req(input logic wr, input int src, input int line);
    drive(1'b1, wr, src, line, 1'b0, 1'b0, 0, 0, 0);
  endtask

  task automatic rsp(input logic wb, input int src, input int line, input int data);
    drive(1'b0, 1'b0, 0, 0, 1'b1, wb, src, line, data);
  endtask

  task automatic chkOut(input string tag, input logic v, input int t, input int dst,
                        input int line, input int data);
    checks++;
    if (outValid !== v || (v && (outType !== 3'(t) || outDst !== NODES'(dst) ||
        outLine !== LW'(line) || outData !== DW'(data)))) begin
      errs++;
      $display("FAIL %s out: v=%0b t=%0d dst=%b line=%0d data=%h | expected v=%0b t=%0d dst=%b line=%0d data=%h",
               tag, outValid, outType, outDst, outLine, outData, v, t, NODES'(dst), line, DW'(data));
    end
  endtask

  task automatic chkCpl(input string tag, input logic v, input int t, input int dst,
                        input int line, input int data);
    checks++;
    if (cplValid !== v || (v && (cplType !== 3'(t) || cplDst !== NODES'(dst) ||
        cplLine !== LW'(line) || cplData !== DW'(data)))) begin
      errs++;
      $display("FAIL %s cpl: v=%0b t=%0d dst=%b line=%0d data=%h | expected v=%0b t=%0d dst=%b line=%0d data=%h",
               tag, cplValid, cplType, cplDst, cplLine, cplData, v, t, NODES'(dst), line, DW'(data));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkOut("R1 idle", 0, 0, 0, 0, 0);
    chkCpl("R1 idle", 0, 0, 0, 0, 0);

    for (int l = 0; l < LINES; l++) begin
      int k, w, r, q, nk, mask, others, nOthers, seen;
      // readers: R1 initial data, R3 read path
      k = l % 4 + 1;
      mask = 0;
      for (int j = 0; j < k; j++) begin
        int s;
        s = (l + j) % 4;
        req(1'b0, s, l);
        chkOut("R1 R3 read", 1, 0, 1 << s, l, l);
        mask |= 1 << s;
      end
      // write: direct grant or invalidation
      w = (l < 4) ? (l + 1) % 4 : l % 4;
      others = mask & ~(1 << w);
      nOthers = 0;
      for (int i = 0; i < NODES; i++) if (others[i]) nOthers++;
      req(1'b1, w, l);
      if (others == 0) begin
        chkOut("R4 direct grant", 1, 1, 1 << w, l, l);
      end else begin
        chkOut("R5 inv mask", 1, 3, others, l, 0);
        nk = (w + 3) % 4;
        req(1'b0, nk, l);
        chkOut("R7 nack busy", 1, 2, 1 << nk, l, 0);
        seen = 0;
        for (int i = 0; i < NODES; i++) begin
          if (others[i]) begin
            rsp(1'b0, i, l, 0);
            seen++;
            if (seen == nOthers) chkCpl("R6 last ack", 1, 1, 1 << w, l, l);
            else chkCpl("R6 early", 0, 0, 0, 0, 0);
          end
        end
      end
      // owner request
      req(1'b0, w, l);
      chkOut("R10 owner hit", 1, 1, 1 << w, l, l);
      // read fetch
      r = (w + 2) % 4;
      req(1'b0, r, l);
      chkOut("R8 fetch", 1, 4, 1 << w, l, 0);
      req(1'b1, (w + 1) % 4, l);
      chkOut("R7 nack fetch", 1, 2, 1 << ((w + 1) % 4), l, 0);
      rsp(1'b1, w, l, 'hA0 + l);
      chkCpl("R9 read wb", 1, 0, 1 << r, l, 'hA0 + l);
      // sharers now owner and reader
      req(1'b1, r, l);
      chkOut("R9 R5 sharers", 1, 3, 1 << w, l, 0);
      rsp(1'b0, w, l, 0);
      chkCpl("R6 single ack", 1, 1, 1 << r, l, 'hA0 + l);
      // write fetch
      q = (r + 1) % 4;
      req(1'b1, q, l);
      chkOut("R8 fetchinv", 1, 5, 1 << r, l, 0);
      rsp(1'b1, r, l, 'hC0 + l);
      chkCpl("R9 write wb", 1, 1, 1 << q, l, 'hC0 + l);
      req(1'b0, q, l);
      chkOut("R9 R10 new owner", 1, 1, 1 << q, l, 'hC0 + l);
      // stray responses
      rsp(1'b0, q, l, 0);
      chkCpl("R12 stray ack", 0, 0, 0, 0, 0);
      chkOut("R12 stray ack", 0, 0, 0, 0, 0);
      rsp(1'b1, (q + 1) % 4, l, 'h55);
      chkCpl("R12 non-owner wb", 0, 0, 0, 0, 0);
      // eviction colliding with a request
      drive(1'b1, 1'b0, (q + 1) % 4, l, 1'b1, 1'b1, q, l, 'hE0 + l);
      chkOut("R11 collide nack", 1, 2, 1 << ((q + 1) % 4), l, 0);
      chkCpl("R11 evict silent", 0, 0, 0, 0, 0);
      req(1'b0, (q + 2) % 4, l);
      chkOut("R11 evicted data", 1, 0, 1 << ((q + 2) % 4), l, 'hE0 + l);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule